// File: doc/BRIEF.md
# Bus-Attached Successive-Approximation Converter Controller

This block is the digital side of an 8-bit multiplexed successive-approximation converter that sits on a microprocessor bus. The host uses three active-low strobes: chip select, write and read. The low address lines of the bus double as the channel-configuration field. On the rising edge of a write, with read high, the block captures that field and starts a conversion. A read of the result also starts a fresh conversion, and so does a write made with read held low. Both of those keep the configuration already held.

A one-bit comparator input answers each trial code that the block presents. The analog multiplexer, the ladder and the comparator all sit outside the block. Bits are resolved from the most significant down, one per clock-enable tick. The finished code is copied into an output latch and an active-low interrupt is raised. The data bus is modelled as a value plus an output enable.

Top module: `adc_bus_front`

## Requirements
- R1: After reset the interrupt output is high, the bus enable is low, the held configuration is 0 and the output latch is 0.
- R2: When the write strobe rises with read high, after a write fall that had chip select low, the 5 address lines are copied into the held configuration and a conversion starts.
- R3: A write fall with chip select low sets the interrupt output high on the next clock.
- R4: A write made while read is low keeps the held configuration and starts a conversion. During that write the bus is enabled and carries the previous result.
- R5: A conversion resolves bits from the MSB down, one per tick. A trial bit is kept when the comparator input is 1, meaning the input is at or above the trial code. The tick after the last bit copies the code into the output latch and drives the interrupt low. With the tick enable held high, this is 9 clocks after the clock that sees the start.
- R6: When the positive input lies below the negative input, the result is 0.
- R7: A read fall with chip select low sets the interrupt high and starts a conversion with the unchanged configuration. While chip select and read are both low, the bus enable is 1 and the bus carries the output latch.
- R8: The bus enable is 0 whenever chip select or read is high.
- R9: A start during an active conversion restarts it from the MSB and leaves the output latch unchanged until the new conversion ends.
- R10: While the tick enable is low, a conversion makes no progress.
- R11: Strobe edges made with chip select high neither change the configuration, start a conversion nor clear the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Conversion clock enable, one sequencer step per high cycle |
| csN | input | 1 | Active-low chip select |
| wrN | input | 1 | Active-low write strobe |
| rdN | input | 1 | Active-low read strobe |
| addrIn | input | 5 | Shared low bus lines carrying the channel configuration |
| cmpIn | input | 1 | Comparator result, 1 when the input is at or above the trial code |
| trialCode | output | 8 | Code presented to the ladder for the current trial |
| muxCfg | output | 5 | Held channel configuration driving the analog multiplexer |
| busOut | output | 8 | Read data value (output latch) |
| busOe | output | 1 | Read data output enable |
| intrN | output | 1 | Active-low conversion-done interrupt |

## Verification
The bench builds the block with its default widths: an 8-bit result and a 5-bit configuration field. With these widths a comparator model can be driven by any positive/negative pair in 0..255, so full-scale, zero, negative-difference and single-MSB codes are all reachable. The 9-clock conversion also stays short enough to count exactly. Because the bench gates the tick enable itself, it can stall a conversion and then resume it, and it can restart a conversion partway through.

// File: rtl/adcFrontPkg.sv
package adcFrontPkg;
  typedef struct packed {
    logic startConv;
    logic loadCfg;
    logic clrIntr;
  } ctlStrobe_t;
endpackage

// File: rtl/adc_bus_decode.sv
module adc_bus_decode
  import adcFrontPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       wrN,
  input  logic       rdN,
  output ctlStrobe_t strb
);
  logic wrNq, rdNq, wrArm;
  logic wrFallSel, wrRise, rdFallSel;

  assign wrFallSel = !csN && wrNq && !wrN;
  assign wrRise    = wrArm && !wrNq && wrN;
  assign rdFallSel = !csN && rdNq && !rdN;

  always_comb begin
    strb.clrIntr   = wrFallSel | rdFallSel;
    strb.startConv = wrRise | rdFallSel;
    strb.loadCfg   = wrRise && rdN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrNq  <= 1'b1;
      rdNq  <= 1'b1;
      wrArm <= 1'b0;
    end else begin
      wrNq <= wrN;
      rdNq <= rdN;
      if (wrFallSel)   wrArm <= 1'b1;
      else if (wrRise) wrArm <= 1'b0;
    end
  end

  // R2
  load_implies_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCfg |-> strb.startConv);

  // R11
  deselect_no_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csN && !wrArm) |-> !strb.clrIntr && !strb.startConv);
endmodule

// File: rtl/adc_sar_path.sv
module adc_sar_path
  import adcFrontPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  ctlStrobe_t        strb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              cmpIn,
  output logic [DATA_W-1:0] trialCode,
  output logic [ADDR_W-1:0] muxCfg,
  output logic [DATA_W-1:0] outLatch,
  output logic              intrN
);
  localparam logic [DATA_W-1:0] TOP_BIT = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] sar, mask;
  logic              busy;
  logic              xferNow;

  assign trialCode = sar | mask;
  assign xferNow   = busy && (mask == '0) && tickEn && !strb.startConv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sar      <= '0;
      mask     <= '0;
      busy     <= 1'b0;
      muxCfg   <= '0;
      outLatch <= '0;
      intrN    <= 1'b1;
    end else begin
      if (strb.loadCfg) muxCfg <= addrIn;
      if (strb.clrIntr) intrN <= 1'b1;
      if (strb.startConv) begin
        busy <= 1'b1;
        sar  <= '0;
        mask <= TOP_BIT;
      end else if (busy && tickEn) begin
        if (mask != '0) begin
          if (cmpIn) sar <= sar | mask;
          mask <= mask >> 1;
        end else begin
          outLatch <= sar;
          intrN    <= 1'b0;
          busy     <= 1'b0;
        end
      end
    end
  end

  // R5
  xfer_raises_intr_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferNow |=> !intrN && (outLatch == $past(sar)));

  // R9
  restart_keeps_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.startConv |=> $stable(outLatch));

  // R10
  no_tick_no_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !strb.startConv) |=> $stable(sar) && $stable(mask) && $stable(outLatch));

  // R2
  cfg_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCfg |=> muxCfg == $past(addrIn));

  // R3
  intr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrIntr && !xferNow) |=> intrN);
endmodule

// File: rtl/adc_bus_front.sv
module adc_bus_front
  import adcFrontPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              csN,
  input  logic              wrN,
  input  logic              rdN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              cmpIn,
  output logic [DATA_W-1:0] trialCode,
  output logic [ADDR_W-1:0] muxCfg,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic              intrN
);
  ctlStrobe_t strb;
  logic [DATA_W-1:0] outLatch;

  adc_bus_decode uDecode (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .rdN(rdN), .strb(strb)
  );

  adc_sar_path #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uPath (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strb(strb), .addrIn(addrIn),
    .cmpIn(cmpIn), .trialCode(trialCode), .muxCfg(muxCfg),
    .outLatch(outLatch), .intrN(intrN)
  );

  assign busOut = outLatch;
  assign busOe  = !csN && !rdN;

  // R8
  oe_needs_cs_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csN || rdN) |-> !busOe);
endmodule

// File: tb/tb_adc_bus_front.sv
module tb_adc_bus_front;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, tickOn = 1'b1;
  logic csN = 1'b1, wrN = 1'b1, rdN = 1'b1, cmpIn;
  logic [4:0] addrIn = '0;
  logic [7:0] trialCode, busOut, posV = '0, negV = '0;
  logic [4:0] muxCfg;
  logic busOe, intrN;
  int nChecks = 0, nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_bus_front dut (
    .clk(clk), .rstN(rstN), .tickEn(tickOn), .csN(csN), .wrN(wrN), .rdN(rdN),
    .addrIn(addrIn), .cmpIn(cmpIn), .trialCode(trialCode), .muxCfg(muxCfg),
    .busOut(busOut), .busOe(busOe), .intrN(intrN)
  );

  // comparator model: input difference against trial code
  always_comb cmpIn = (int'(posV) - int'(negV)) >= int'(trialCode);

  // {addr, pos, neg, expected}
  localparam logic [28:0] VEC [6] = '{
    {5'h00, 8'd200, 8'd0,   8'd200},
    {5'h0B, 8'd100, 8'd40,  8'd60},
    {5'h15, 8'd0,   8'd0,   8'd0},
    {5'h1F, 8'd255, 8'd0,   8'd255},
    {5'h0A, 8'd30,  8'd90,  8'd0},
    {5'h12, 8'd129, 8'd1,   8'd128}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [4:0] a);
    @(negedge clk); csN = 1'b0; addrIn = a;
    @(negedge clk); wrN = 1'b0;
    @(negedge clk); wrN = 1'b1; csN = 1'b1;
  endtask

  task automatic doRead(output logic [7:0] d, output logic oe, output logic irq);
    @(negedge clk); csN = 1'b0; rdN = 1'b0;
    @(negedge clk); d = busOut; oe = busOe; irq = intrN;
    rdN = 1'b1; csN = 1'b1;
  endtask

  task automatic waitDone(output int k);
    k = 0;
    while (intrN && k < 100) begin
      @(negedge clk); k++;
    end
    if (intrN) chk(1'b0, "watchdog waitDone", 1, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    chk(1'b0, "global watchdog", 1, 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [7:0] d; logic oe, irq; int k;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(intrN == 1'b1 && busOe == 1'b0, "R1 intr/oe", {intrN, busOe}, 2);
    chk(muxCfg == 5'd0 && busOut == 8'd0, "R1 cfg/latch", {muxCfg, busOut}, 0);
    rstN = 1'b1;

    for (int i = 0; i < 6; i++) begin
      posV = VEC[i][23:16]; negV = VEC[i][15:8];
      doWrite(VEC[i][28:24]);
      waitDone(k);
      chk(k == 10, "R5 latency", k, 10);
      chk(muxCfg == VEC[i][28:24], "R2 cfg capture", muxCfg, VEC[i][28:24]);
      doRead(d, oe, irq);
      chk(d == VEC[i][7:0], "R5/R6 result", d, VEC[i][7:0]);
      chk(oe == 1'b1 && irq == 1'b1, "R7 read oe/intr", {oe, irq}, 3);
      waitDone(k);
      chk(k == 9, "R7 read restart latency", k, 9);
    end

    // R7: read-started conversion keeps configuration and result
    chk(muxCfg == 5'h12, "R7 cfg kept", muxCfg, 5'h12);
    doRead(d, oe, irq);
    chk(d == 8'd128, "R7 reconvert", d, 128);
    waitDone(k);

    // R8: enable off when one of cs/rd is high
    @(negedge clk); csN = 1'b1; rdN = 1'b0;
    @(negedge clk); chk(busOe == 1'b0, "R8 cs high", busOe, 0);
    rdN = 1'b1; csN = 1'b0;
    @(negedge clk); chk(busOe == 1'b0, "R8 rd high", busOe, 0);
    csN = 1'b1;

    // R11: deselected write and read ignored
    @(negedge clk); addrIn = 5'h07; wrN = 1'b0;
    @(negedge clk); wrN = 1'b1;
    @(negedge clk); rdN = 1'b0;
    @(negedge clk); rdN = 1'b1;
    repeat (12) @(negedge clk);
    chk(muxCfg == 5'h12, "R11 cfg unchanged", muxCfg, 5'h12);
    chk(intrN == 1'b0, "R11 intr not cleared", intrN, 0);

    // R3: write fall clears interrupt
    posV = 8'd77; negV = 8'd0;
    @(negedge clk); csN = 1'b0; addrIn = 5'h03;
    @(negedge clk); wrN = 1'b0;
    @(negedge clk); chk(intrN == 1'b1, "R3 intr cleared", intrN, 1);
    wrN = 1'b1; csN = 1'b1;
    waitDone(k);
    chk(k == 10 && muxCfg == 5'h03, "R2 second write", {k, muxCfg}, {10, 3});

    // R4: write with read low keeps config, drives previous result
    posV = 8'd5;
    @(negedge clk); csN = 1'b0; rdN = 1'b0; addrIn = 5'h1C;
    @(negedge clk); wrN = 1'b0;
    @(negedge clk);
    chk(busOe == 1'b1 && busOut == 8'd77, "R4 bus during write", busOut, 77);
    wrN = 1'b1;
    @(negedge clk); rdN = 1'b1; csN = 1'b1;
    waitDone(k);
    chk(k == 9, "R4 start latency", k, 9);
    chk(muxCfg == 5'h03, "R4 cfg kept", muxCfg, 3);
    doRead(d, oe, irq);
    chk(d == 8'd5, "R4 result", d, 5);
    waitDone(k);

    // R9: restart mid-conversion keeps latch
    posV = 8'd50;
    doWrite(5'h04);
    repeat (4) @(negedge clk);
    posV = 8'd99;
    doRead(d, oe, irq);
    chk(d == 8'd5 && intrN == 1'b1, "R9 latch unchanged", d, 5);
    waitDone(k);
    chk(k == 9, "R9 restart latency", k, 9);
    doRead(d, oe, irq);
    chk(d == 8'd99, "R9 new result", d, 99);
    waitDone(k);

    // R10: stalled without ticks
    tickOn = 1'b0; posV = 8'd170;
    doWrite(5'h09);
    repeat (20) @(negedge clk);
    chk(intrN == 1'b1, "R10 stalled", intrN, 1);
    tickOn = 1'b1;
    waitDone(k);
    chk(k == 9, "R10 resume ticks", k, 9);
    doRead(d, oe, irq);
    chk(d == 8'd170, "R10 result", d, 170);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule